// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This peripheral counts down on a divided version of the system clock. It has a small register bus. A write strobe, a word index and write data update its registers, and read data is returned combinationally for the word index on the bus. Software sets a start value and a reload value, and chooses one of three counting modes:

- **Periodic** reloads the counter from the stored limit.
- **Free-running** wraps to the largest value of the selected width.
- **One-shot** parks at zero.

Each arrival at zero latches a raw interrupt flag. A single level-sensitive interrupt line shows that flag gated by an enable bit.

The counter can run 16 or 32 bits wide. In 16-bit mode only the low half takes part in counting, wrapping and reading. A prescaler lets the counter step on every clock, every 16th clock or every 256th clock.

Top module: `count_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only, counting off), the value register reads 0, both status registers read 0 and `irq` is low.
- R2: Word indexes: 0 load, 1 value (read-only), 2 control, 3 interrupt clear (write-only), 4 raw status in bit 0, 5 masked status in bit 0, 6 background load. Writes to indexes 1, 4 and 5 change nothing. Indexes 3 and 7 read 0. Indexes 0 and 6 both read the stored limit.
- R3: A write to index 0 stores the limit and places the written value in the counter on the same clock edge.
- R4: A write to index 6 stores the limit only. A running count keeps decrementing and takes up the new limit at its next periodic wrap.
- R5: Control bit 7 enables counting. While it is set, each prescaled tick lowers a nonzero count by one. While it is clear, the count holds.
- R6: Periodic mode (bit 6 set, bit 0 clear): a tick that finds the count at zero reloads it from the limit.
- R7: Free-running mode (bits 6 and 0 clear): a tick at zero reloads 0xFFFF when size bit 1 is clear and 0xFFFFFFFF when it is set.
- R8: One-shot mode (bit 0 set, taking precedence over bit 6): the count stays at zero on later ticks. A control write that sets bit 7 while the count is zero reloads the count from the limit.
- R9: A tick that takes the count from 1 to 0 sets the raw flag. Any write to index 3 clears it, unless a setting tick falls in the same cycle, in which case the flag is set.
- R10: `irq` and the masked status both equal the raw flag ANDed with control bit 5.
- R11: Control bits [3:2] choose the tick rate: 0 or 3 gives every enabled cycle, 1 gives every 16th, 2 gives every 256th. The prescaler restarts when counting is off and on a write to index 0.
- R12: With size bit 1 clear, the value register reads the low 16 bits of the counter, zero-extended, and only those bits decrement.
- R13: In one cycle, a load write wins over a re-enable reload, which wins over a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 3 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `reg_idx` |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a prescaled tick that lines up exactly with a register write. Examples are a load arriving on the same edge as a decrement, or a background load arriving while the counter is mid-period. The stimulus reaches these cases by using the write task's known edge: the bench enables the timer, counts idle cycles to the predicted tick, and issues the write on that edge. For the divide-by-16 and divide-by-256 rates, the bench waits exactly one cycle short of the expected step and samples there, then samples again one cycle later.

// File: rtl/count_timer.sv
module count_timer #(
  parameter int IDX_W = 3,
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [7:0] CTRL_RST = 8'h20;
  localparam logic [CNT_W-1:0] HALF_MAX = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] cnt_q, limit_q, cnt_eff, wrap_val;
  logic [PRE_W-1:0] pre_q;
  logic             raw_q, tick, wr_load, wr_ctrl, wr_clr, wr_bg, re_arm, hit_zero;

  wire one_shot = ctrl_q[0];
  wire wide     = ctrl_q[1];
  wire run      = ctrl_q[7];

  assign wr_load = bus_we && reg_idx == IDX_W'(0);
  assign wr_ctrl = bus_we && reg_idx == IDX_W'(2);
  assign wr_clr  = bus_we && reg_idx == IDX_W'(3);
  assign wr_bg   = bus_we && reg_idx == IDX_W'(6);

  assign cnt_eff = wide ? cnt_q : {{HALF_W{1'b0}}, cnt_q[HALF_W-1:0]};

  always_comb begin
    case (ctrl_q[3:2])
      2'd1:    tick = run && (pre_q[3:0] == 4'hF);
      2'd2:    tick = run && (pre_q == '1);
      default: tick = run;
    endcase
  end

  always_comb begin
    if (one_shot)       wrap_val = '0;
    else if (ctrl_q[6]) wrap_val = limit_q;
    else if (wide)      wrap_val = '1;
    else                wrap_val = HALF_MAX;
  end

  assign re_arm   = wr_ctrl && bus_wdata[7] && cnt_eff == '0;
  assign hit_zero = tick && !wr_load && !re_arm && cnt_eff == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || wr_load) pre_q <= '0;
    else                           pre_q <= pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      limit_q <= '0;
      cnt_q   <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_ctrl)         ctrl_q  <= bus_wdata[7:0];
      if (wr_load || wr_bg) limit_q <= bus_wdata;

      if (wr_load)     cnt_q <= bus_wdata;
      else if (re_arm) cnt_q <= limit_q;
      else if (tick)   cnt_q <= (cnt_eff != '0) ? cnt_eff - CNT_W'(1) : wrap_val;

      if (hit_zero)    raw_q <= 1'b1;
      else if (wr_clr) raw_q <= 1'b0;
    end
  end

  assign irq = raw_q && ctrl_q[5];

  always_comb begin
    case (reg_idx)
      IDX_W'(0), IDX_W'(6): bus_rdata = limit_q;
      IDX_W'(1):            bus_rdata = cnt_eff;
      IDX_W'(2):            bus_rdata = {{(CNT_W-8){1'b0}}, ctrl_q};
      IDX_W'(4):            bus_rdata = {{(CNT_W-1){1'b0}}, raw_q};
      IDX_W'(5):            bus_rdata = {{(CNT_W-1){1'b0}}, irq};
      default:              bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/count_timer_chk.sv
module count_timer_chk #(
  parameter int IDX_W = 3,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] reg_idx,
  input logic             bus_we,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [7:0]       ctrl_q,
  input logic             raw_q
);
  localparam int HALF_W = CNT_W / 2;
  wire ld  = bus_we && reg_idx == IDX_W'(0);
  wire cw  = bus_we && reg_idx == IDX_W'(2);
  wire clr = bus_we && reg_idx == IDX_W'(3);
  wire [CNT_W-1:0] eff = ctrl_q[1] ? cnt_q : {{HALF_W{1'b0}}, cnt_q[HALF_W-1:0]};

  a_r3_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(bus_wdata));

  a_r5_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[7] && !ld && !cw) |=> $stable(cnt_q));

  a_r8_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && cnt_q == '0 && !ld && !cw) |=> cnt_q == '0);

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && eff != CNT_W'(1)) |=> !raw_q);

  a_r9_set_from_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> ($past(eff) == CNT_W'(1) && $past(ctrl_q[7])));

  a_r10_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw_q);
endmodule

bind count_timer count_timer_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq(irq), .cnt_q(cnt_q), .ctrl_q(ctrl_q), .raw_q(raw_q));

// File: tb/count_timer_test.sv
`timescale 1ns/1ps
module count_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  count_timer uut (.clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .bus_we(bus_we),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // {we, idx, data, expected read}
  localparam logic [67:0] VEC [19] = '{
    {1'b1, 3'd0, 32'h12345678, 32'h0},
    {1'b0, 3'd0, 32'h0, 32'h12345678},
    {1'b0, 3'd1, 32'h0, 32'h00005678},
    {1'b0, 3'd6, 32'h0, 32'h12345678},
    {1'b1, 3'd6, 32'hAAAA0001, 32'h0},
    {1'b0, 3'd0, 32'h0, 32'hAAAA0001},
    {1'b0, 3'd1, 32'h0, 32'h00005678},
    {1'b1, 3'd1, 32'h0000DEAD, 32'h0},
    {1'b0, 3'd1, 32'h0, 32'h00005678},
    {1'b1, 3'd4, 32'h1, 32'h0},
    {1'b0, 3'd4, 32'h0, 32'h0},
    {1'b1, 3'd5, 32'h1, 32'h0},
    {1'b0, 3'd5, 32'h0, 32'h0},
    {1'b0, 3'd3, 32'h0, 32'h0},
    {1'b0, 3'd7, 32'h0, 32'h0},
    {1'b1, 3'd2, 32'h22, 32'h0},
    {1'b0, 3'd2, 32'h0, 32'h22},
    {1'b0, 3'd1, 32'h0, 32'h12345678},
    {1'b1, 3'd2, 32'h20, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    reg_idx = i; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] i, input logic [31:0] exp);
    reg_idx = i;
    #0.5;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired got=%h exp=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    rdchk("R1 ctrl", 3'd2, 32'h20);
    rdchk("R1 value", 3'd1, 32'h0);
    rdchk("R1 raw", 3'd4, 32'h0);
    rdchk("R1 masked", 3'd5, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 19; i++) begin
      if (VEC[i][67]) wr(VEC[i][66:64], VEC[i][63:32]);
      else rdchk($sformatf("R2/R12 vec%0d", i), VEC[i][66:64], VEC[i][31:0]);
    end

    // periodic, 32-bit, divide by 1
    wr(3'd0, 32'd3);
    wr(3'd2, 32'hE2);
    rdchk("R3 load", 3'd1, 32'd3);
    step(1); rdchk("R5 dec", 3'd1, 32'd2);
    step(1); rdchk("R5 dec", 3'd1, 32'd1);
    step(1); rdchk("R9 zero", 3'd1, 32'd0);
    chk("R10 irq", {31'b0, irq}, 32'h1);
    rdchk("R9 raw", 3'd4, 32'h1);
    rdchk("R10 masked", 3'd5, 32'h1);
    step(1); rdchk("R6 reload", 3'd1, 32'd3);
    wr(3'd2, 32'h62);
    rdchk("R5 last tick", 3'd1, 32'd2);
    step(3); rdchk("R5 hold", 3'd1, 32'd2);
    wr(3'd3, 32'h0);
    rdchk("R9 clear", 3'd4, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);

    // interrupt masked
    wr(3'd0, 32'd1);
    wr(3'd2, 32'hC2);
    step(1);
    chk("R10 masked irq", {31'b0, irq}, 32'h0);
    rdchk("R10 masked st", 3'd5, 32'h0);
    rdchk("R9 raw set", 3'd4, 32'h1);
    wr(3'd2, 32'h42);
    wr(3'd3, 32'h0);

    // one-shot
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA3);
    rdchk("R8 start", 3'd1, 32'd2);
    step(2); rdchk("R8 zero", 3'd1, 32'd0);
    chk("R9 oneshot irq", {31'b0, irq}, 32'h1);
    step(5); rdchk("R8 parked", 3'd1, 32'd0);
    wr(3'd3, 32'h0);
    chk("R8 no reset flag", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'hA3);
    rdchk("R8 re-arm", 3'd1, 32'd2);
    step(2); rdchk("R8 second", 3'd1, 32'd0);
    wr(3'd2, 32'h23);
    wr(3'd3, 32'h0);

    // free-running 16 and 32
    wr(3'd0, 32'd1);
    wr(3'd2, 32'hA0);
    step(2); rdchk("R7 R12 wrap16", 3'd1, 32'h0000FFFF);
    wr(3'd2, 32'h20);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'd1);
    wr(3'd2, 32'hA2);
    step(2); rdchk("R7 wrap32", 3'd1, 32'hFFFFFFFF);
    wr(3'd2, 32'h22);
    wr(3'd3, 32'h0);

    // background load while running
    wr(3'd0, 32'd5);
    wr(3'd2, 32'hE2);
    wr(3'd6, 32'd2);
    rdchk("R4 continues", 3'd1, 32'd4);
    rdchk("R4 limit", 3'd0, 32'd2);
    step(4); rdchk("R4 zero", 3'd1, 32'd0);
    step(1); rdchk("R4 new limit", 3'd1, 32'd2);
    wr(3'd0, 32'd9);
    rdchk("R13 load wins", 3'd1, 32'd9);
    step(1); rdchk("R13 after", 3'd1, 32'd8);
    wr(3'd2, 32'h62);
    wr(3'd3, 32'h0);

    // prescaler
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hE6);
    step(15); rdchk("R11 div16 wait", 3'd1, 32'd2);
    step(1); rdchk("R11 div16 tick", 3'd1, 32'd1);
    wr(3'd2, 32'h66);
    wr(3'd0, 32'd1);
    wr(3'd2, 32'hEA);
    step(255); rdchk("R11 div256 wait", 3'd1, 32'd1);
    step(1); rdchk("R11 div256 tick", 3'd1, 32'd0);
    wr(3'd2, 32'h6A);
    wr(3'd3, 32'h0);

    finish_run();
  end
endmodule